// File: doc/BRIEF.md
# Overriding Second-Level Branch Checker

A fast first-level predictor steers fetch every cycle with no bubble and reports each branch it predicted, tagged with a sequence number, its direction, its taken target and its fall-through address. A larger, slower second-level predictor looks at the same branches one or two cycles later. This block holds the first-level guesses that still wait for a second opinion. When a slow result arrives, the block compares it with the stored guess.

When the two levels agree, the block stays quiet. When they disagree, the block asks for a flush. The flush carries the sequence tag of the disputed branch, so that every fetch-queue entry younger than that tag is discarded. It also carries the address fetch must restart from. Several slow results can arrive in one cycle, one per lane, and only the oldest disagreement is reported. A flush from the execution stage overrides all of this and cancels every pending check.

Top module: `ovr_branch_checker`

## Requirements
- R1: After reset, `rs_valid` is 0 and no prediction is pending.
- R2: A slow result that gives the same direction as the pending guess, and the same target when both say taken, raises no flush.
- R3: A slow result with a different direction raises `rs_valid` with `rs_seq` set to the branch tag. `rs_pc` is the slow target when the slow level says taken, and the stored fall-through address when it says not taken.
- R4: When both levels say taken but the targets differ, a flush is raised with `rs_pc` equal to the slow target.
- R5: When both levels say not taken, a difference in the target fields raises no flush.
- R6: Among the disagreements seen in one cycle, only the oldest tag is flushed. Tag a is younger than tag b when (a - b) modulo 2^SEQ_W lies in 1 .. 2^(SEQ_W-1)-1, so tag 0 is younger than tag 31 for 5-bit tags.
- R7: When `ex_flush` is high, no resteer is reported for that cycle, and every pending check is cancelled. Later slow results for those tags raise no flush.
- R8: A resteer discards the pending checks younger than the flushed tag, and later slow results for them raise nothing. Older pending checks stay live.
- R9: A slow result whose tag has no pending guess is ignored. This covers a tag already checked once.
- R10: `rs_valid` rises on the clock edge that samples the disputed slow result and is a one-cycle pulse for each reported disagreement.
- R11: A first-level prediction presented in a cycle with `ex_flush` or a resteer is not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_valid | input | 1 | First-level prediction present |
| fp_seq | input | SEQ_W | Tag of the predicted branch |
| fp_taken | input | 1 | First-level direction |
| fp_target | input | ADDR_W | First-level taken target |
| fp_fallthru | input | ADDR_W | Address after the branch |
| sp_valid | input | LANES | Slow result present, one bit per lane |
| sp_seq | input | LANES*SEQ_W | Tags of the slow results |
| sp_taken | input | LANES | Slow directions |
| sp_target | input | LANES*ADDR_W | Slow taken targets |
| ex_flush | input | 1 | Flush from execution, highest priority |
| rs_valid | output | 1 | Resteer request |
| rs_seq | output | SEQ_W | Tag of the disputed branch |
| rs_pc | output | ADDR_W | Fetch restart address |

## Verification
The embedded assertions check on every cycle that the lane selection is at most one-hot, that it falls on a lane that really disagrees, that an execution flush empties the pending store and hides any resteer, that both-not-taken lanes never disagree, and that every resteer pulse follows a detected disagreement. Only the bench scenarios can show the actual restart address and tag values. They also show which of two disagreeing lanes wins across tag wrap-around, and that younger checks vanish after a resteer while older ones remain. Finally, they show that stale, repeated or cancelled slow results stay silent.

// File: rtl/ovr_pkg.sv
package ovr_pkg;
  localparam int SEQ_W  = 5;
  localparam int ADDR_W = 32;

  typedef logic [SEQ_W-1:0]  seq_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // a is younger than b when the forward distance from b to a is in the lower half
  function automatic logic seq_younger(seq_t a, seq_t b);
    seq_t d;
    d = a - b;
    return (d != '0) && !d[SEQ_W-1];
  endfunction

  // two levels disagree on direction, or on target while both taken
  function automatic logic levels_differ(logic f_tk, addr_t f_tg, logic s_tk, addr_t s_tg);
    return (f_tk != s_tk) || (f_tk && s_tk && (f_tg != s_tg));
  endfunction

  function automatic addr_t restart_pc(logic s_tk, addr_t s_tg, addr_t fall);
    return s_tk ? s_tg : fall;
  endfunction
endpackage

// File: rtl/ovr_track_table.sv
module ovr_track_table
  import ovr_pkg::*;
#(
  parameter int LANES = 2,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  seq_t              wr_seq,
  input  logic              wr_taken,
  input  addr_t             wr_target,
  input  addr_t             wr_fall,
  input  logic [LANES-1:0]  lk_valid,
  input  seq_t              lk_seq   [LANES],
  output logic [LANES-1:0]  lk_hit,
  output logic [LANES-1:0]  lk_taken,
  output addr_t             lk_target[LANES],
  output addr_t             lk_fall  [LANES],
  input  logic              kill_all,
  input  logic              rs_fire,
  input  seq_t              rs_tag
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] vld_q;
  seq_t             seq_q   [DEPTH];
  logic             tk_q    [DEPTH];
  addr_t            tgt_q   [DEPTH];
  addr_t            fall_q  [DEPTH];
  logic [DEPTH-1:0] consume;

  for (genvar l = 0; l < LANES; l++) begin : g_look
    logic [IDX_W-1:0] ix;
    assign ix           = lk_seq[l][IDX_W-1:0];
    assign lk_hit[l]    = lk_valid[l] && vld_q[ix] && (seq_q[ix] == lk_seq[l]);
    assign lk_taken[l]  = tk_q[ix];
    assign lk_target[l] = tgt_q[ix];
    assign lk_fall[l]   = fall_q[ix];
  end

  always_comb begin
    consume = '0;
    for (int l = 0; l < LANES; l++)
      if (lk_hit[l]) consume[lk_seq[l][IDX_W-1:0]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (kill_all) begin
      vld_q <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++)
        if (consume[e] || (rs_fire && seq_younger(seq_q[e], rs_tag)))
          vld_q[e] <= 1'b0;
      if (wr_en && !rs_fire)
        vld_q[wr_seq[IDX_W-1:0]] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !rs_fire && !kill_all) begin
      seq_q [wr_seq[IDX_W-1:0]] <= wr_seq;
      tk_q  [wr_seq[IDX_W-1:0]] <= wr_taken;
      tgt_q [wr_seq[IDX_W-1:0]] <= wr_target;
      fall_q[wr_seq[IDX_W-1:0]] <= wr_fall;
    end
  end

  AST_EX_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(kill_all) |-> (vld_q == '0)); // R7
endmodule

// File: rtl/ovr_lane_cmp.sv
module ovr_lane_cmp
  import ovr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hit,
  input  logic  f_taken,
  input  addr_t f_target,
  input  addr_t f_fall,
  input  logic  s_taken,
  input  addr_t s_target,
  output logic  mism,
  output addr_t corr_pc
);
  assign mism    = hit && levels_differ(f_taken, f_target, s_taken, s_target);
  assign corr_pc = restart_pc(s_taken, s_target, f_fall);

  AST_NT_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !f_taken && !s_taken) |-> !mism); // R5
endmodule

// File: rtl/ovr_oldest_pick.sv
module ovr_oldest_pick
  import ovr_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] mism,
  input  seq_t             tag [LANES],
  input  addr_t            pc  [LANES],
  output logic [LANES-1:0] pick_oh,
  output logic             pick_any,
  output seq_t             pick_seq,
  output addr_t            pick_pc
);
  always_comb begin
    pick_oh  = '0;
    pick_any = 1'b0;
    pick_seq = '0;
    pick_pc  = '0;
    for (int l = 0; l < LANES; l++) begin
      if (mism[l] && (!pick_any || seq_younger(pick_seq, tag[l]))) begin
        pick_oh     = '0;
        pick_oh[l]  = 1'b1;
        pick_any    = 1'b1;
        pick_seq    = tag[l];
        pick_pc     = pc[l];
      end
    end
  end

  AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh)); // R6
  AST_PICK_REAL: assert property (@(posedge clk) disable iff (!rst_n)
    pick_any |-> ((pick_oh & mism) != '0)); // R6
endmodule

// File: rtl/ovr_branch_checker.sv
module ovr_branch_checker
  import ovr_pkg::*;
#(
  parameter int LANES = 2,
  parameter int IDX_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fp_valid,
  input  logic [SEQ_W-1:0]        fp_seq,
  input  logic                    fp_taken,
  input  logic [ADDR_W-1:0]       fp_target,
  input  logic [ADDR_W-1:0]       fp_fallthru,
  input  logic [LANES-1:0]        sp_valid,
  input  logic [LANES*SEQ_W-1:0]  sp_seq,
  input  logic [LANES-1:0]        sp_taken,
  input  logic [LANES*ADDR_W-1:0] sp_target,
  input  logic                    ex_flush,
  output logic                    rs_valid,
  output logic [SEQ_W-1:0]        rs_seq,
  output logic [ADDR_W-1:0]       rs_pc
);
  seq_t             lane_seq [LANES];
  addr_t            lane_tgt [LANES];
  logic [LANES-1:0] hit, st_tk;
  addr_t            st_tgt [LANES];
  addr_t            st_fall[LANES];
  logic [LANES-1:0] mism;
  addr_t            corr   [LANES];
  logic [LANES-1:0] pick_oh;
  logic             pick_any;
  seq_t             pick_seq;
  addr_t            pick_pc;
  logic             resteer_now;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_seq[l] = sp_seq[l*SEQ_W +: SEQ_W];
    assign lane_tgt[l] = sp_target[l*ADDR_W +: ADDR_W];
    ovr_lane_cmp u_cmp (
      .clk(clk), .rst_n(rst_n), .hit(hit[l]),
      .f_taken(st_tk[l]), .f_target(st_tgt[l]), .f_fall(st_fall[l]),
      .s_taken(sp_taken[l]), .s_target(lane_tgt[l]),
      .mism(mism[l]), .corr_pc(corr[l])
    );
  end

  ovr_oldest_pick #(.LANES(LANES)) u_pick (
    .clk(clk), .rst_n(rst_n), .mism(mism), .tag(lane_seq), .pc(corr),
    .pick_oh(pick_oh), .pick_any(pick_any), .pick_seq(pick_seq), .pick_pc(pick_pc)
  );

  assign resteer_now = pick_any && !ex_flush;

  ovr_track_table #(.LANES(LANES), .IDX_W(IDX_W)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fp_valid), .wr_seq(fp_seq), .wr_taken(fp_taken),
    .wr_target(fp_target), .wr_fall(fp_fallthru),
    .lk_valid(sp_valid), .lk_seq(lane_seq), .lk_hit(hit),
    .lk_taken(st_tk), .lk_target(st_tgt), .lk_fall(st_fall),
    .kill_all(ex_flush), .rs_fire(resteer_now), .rs_tag(pick_seq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_seq   <= '0;
      rs_pc    <= '0;
    end else begin
      rs_valid <= resteer_now;
      if (resteer_now) begin
        rs_seq <= pick_seq;
        rs_pc  <= pick_pc;
      end
    end
  end

  AST_EX_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ex_flush) |-> !rs_valid); // R7
  AST_RS_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> $past(mism != '0)); // R10
endmodule

// File: tb/ovr_branch_checker_tb.sv
module ovr_branch_checker_tb_top;
  localparam int SW = 5;
  localparam int AW = 32;
  localparam int LN = 2;
  localparam int NV = 6;

  logic clk = 0, rst_n = 0;
  logic fp_valid, fp_taken, ex_flush;
  logic [SW-1:0] fp_seq;
  logic [AW-1:0] fp_target, fp_fallthru;
  logic [LN-1:0] sp_valid, sp_taken;
  logic [LN*SW-1:0] sp_seq;
  logic [LN*AW-1:0] sp_target;
  logic rs_valid;
  logic [SW-1:0] rs_seq;
  logic [AW-1:0] rs_pc;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ovr_branch_checker dut_i (.*);

  // {f_taken, f_tgt, f_fall, s_taken, s_tgt, exp_flush, exp_pc}
  localparam logic [66:0] VEC [NV] = '{
    {1'b1, 16'h1000, 16'h0104, 1'b1, 16'h1000, 1'b0, 16'h0000},  // R2
    {1'b0, 16'h2000, 16'h0108, 1'b0, 16'h3000, 1'b0, 16'h0000},  // R5
    {1'b1, 16'h2000, 16'h0200, 1'b0, 16'h0000, 1'b1, 16'h0200},  // R3
    {1'b0, 16'h0000, 16'h0300, 1'b1, 16'h4000, 1'b1, 16'h4000},  // R3
    {1'b1, 16'h5000, 16'h0400, 1'b1, 16'h5400, 1'b1, 16'h5400},  // R4
    {1'b1, 16'h1234, 16'h0500, 1'b1, 16'h1234, 1'b0, 16'h0000}   // R2
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    fp_valid = 0; fp_taken = 0; fp_seq = '0; fp_target = '0; fp_fallthru = '0;
    sp_valid = '0; sp_taken = '0; sp_seq = '0; sp_target = '0; ex_flush = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1; idle();
  endtask

  task automatic fast(int s, bit tk, int tg, int fl);
    fp_valid = 1; fp_seq = SW'(s); fp_taken = tk;
    fp_target = AW'(tg); fp_fallthru = AW'(fl);
  endtask

  task automatic slow(int l, int s, bit tk, int tg);
    sp_valid[l] = 1; sp_seq[l*SW +: SW] = SW'(s);
    sp_taken[l] = tk; sp_target[l*AW +: AW] = AW'(tg);
  endtask

  initial begin
    #(4 * 20000);
    $display("FAIL watchdog actual=timeout expected=done");
    errors++;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 reset rs_valid", rs_valid, 0);
    slow(0, 0, 1, 'h99); tick();
    chk("R1 nothing pending", rs_valid, 0);

    for (int v = 0; v < NV; v++) begin
      fast(v, VEC[v][66], VEC[v][65:50], VEC[v][49:34]); tick();
      slow(0, v, VEC[v][33], VEC[v][32:17]); tick();
      chk("R2/R3/R4/R5 flush", rs_valid, VEC[v][16]);
      if (VEC[v][16]) begin
        chk("R3/R4 rs_pc", rs_pc, VEC[v][15:0]);
        chk("R3 rs_seq", rs_seq, v);
      end
    end

    // R10: one-cycle pulse
    fast(9, 1, 'h700, 'h124); tick();
    slow(0, 9, 0, 0); tick();
    chk("R10 pulse high", rs_valid, 1);
    tick();
    chk("R10 pulse low", rs_valid, 0);

    // R6: oldest across wrap
    ex_flush = 1; tick();
    fast(31, 1, 'hA00, 'hB00); tick();
    fast(0, 1, 'hC00, 'hD00); tick();
    slow(0, 0, 0, 0); slow(1, 31, 0, 0); tick();
    chk("R6 oldest tag", rs_seq, 31);
    chk("R6 oldest pc", rs_pc, 'hB00);

    // R8: younger discarded, older kept
    ex_flush = 1; tick();
    fast(1, 1, 'h10, 'h11); tick();
    fast(2, 1, 'h20, 'h21); tick();
    fast(3, 1, 'h30, 'h31); tick();
    slow(0, 2, 0, 0); tick();
    chk("R8 flush tag 2", rs_seq, 2);
    slow(0, 3, 0, 0); tick();
    chk("R8 younger discarded", rs_valid, 0);
    slow(0, 1, 0, 0); tick();
    chk("R8 older kept", rs_valid, 1);
    chk("R8 older pc", rs_pc, 'h11);

    // R7: execution flush wins and cancels
    fast(4, 1, 'h40, 'h41); tick();
    fast(5, 1, 'h50, 'h51); tick();
    slow(0, 4, 0, 0); ex_flush = 1; tick();
    chk("R7 ex flush silences", rs_valid, 0);
    slow(0, 5, 0, 0); tick();
    chk("R7 pending cancelled", rs_valid, 0);

    // R9: unknown and repeated tags
    slow(0, 6, 0, 0); tick();
    chk("R9 unknown tag", rs_valid, 0);
    fast(7, 1, 'h70, 'h71); tick();
    slow(0, 7, 1, 'h70); tick();
    chk("R9 agree first", rs_valid, 0);
    slow(0, 7, 0, 0); tick();
    chk("R9 repeat ignored", rs_valid, 0);

    // R11: prediction during flush dropped
    fast(8, 1, 'h80, 'h81); ex_flush = 1; tick();
    slow(0, 8, 0, 0); tick();
    chk("R11 dropped on ex flush", rs_valid, 0);
    fast(10, 1, 'hE0, 'hE1); tick();
    fast(12, 1, 'hF0, 'hF1); slow(0, 10, 0, 0); tick();
    chk("R11 resteer flush", rs_seq, 10);
    slow(0, 12, 0, 0); tick();
    chk("R11 dropped on resteer", rs_valid, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule